// File: doc/BRIEF.md
# Disjoint Bidirectional Routing Junction

This block is the junction placed where a horizontal and a vertical routing channel of a small programmable fabric cross. It has four sides (north, east, south, west). Each side carries three bidirectional tracks. Track k on one side can only be joined to track k on the other three sides, so the junction holds one switch unit per track index. Each unit has a switch for every pair of sides, which gives six switches per unit. A switch is built from two opposing tristate drivers, so it can pass a signal in either direction, or in neither.

The switch settings come from a serial configuration chain. This lets many junctions be daisy-chained and loaded through a single bit stream. While the chain is shifting, and after reset, no track is driven. A track that no switch drives is left at high impedance for the surrounding fabric to resolve.

Top module: `rbox_disjoint`

## Requirements
- R1: A synchronous active-high `rst` clears every configuration bit to 0. After reset no track on any side is driven, and `cfg_dout` reads 0.
- R2: While `cfg_shift` is high, each rising clock edge shifts the chain by one: `cfg_din` enters bit 0 and every bit moves up one place. `cfg_dout` always shows bit 35, so a bit reappears at `cfg_dout` 36 shifts after it entered, and a word sent most-significant bit first lands with bit 35 at the top. While `cfg_shift` is low the chain holds its contents.
- R3: While `cfg_shift` is high, every tristate driver is off in that same cycle, whatever the stored bits are.
- R4: Sides are numbered N=0, E=1, S=2, W=3. Switch p joins a side pair in this order: 0=(N,E), 1=(N,S), 2=(N,W), 3=(E,S), 4=(E,W), 5=(S,W). For each pair the first side is A and the second is B. For track t, configuration bit t*12+2p set alone drives B from A. Bit t*12+2p+1 set alone drives A from B.
- R5: A setting for track k never puts a value on a track with a different index on any side.
- R6: A switch with both of its bits set drives in neither direction.
- R7: A track that no enabled switch targets is not driven by the block.
- R8: A routed track carries the value of its source side, in every direction. One source may fan out to all three other sides at once.
- R9: If several switches target the same side of one track, only the switch with the lowest pair number drives it.
- R10: A track that the block drives always carries the same value as the source track selected for it. There is never a second driver on that track inside the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset; clears the configuration |
| cfg_shift | input | 1 | Shift enable for the chain; also forces all drivers off |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, to the next junction |
| io_n | inout | TRACKS | North side tracks |
| io_e | inout | TRACKS | East side tracks |
| io_s | inout | TRACKS | South side tracks |
| io_w | inout | TRACKS | West side tracks |

## Verification
The hardest situation to create from the ports is telling an undriven track apart from one that is driven with the same value. The bench places weak pull-downs on every track. It then drives each routed source with both a 1 and a 0, so a track the block leaves floating shows up as a stuck 0 when the source is high. Random star-shaped settings are loaded through the chain. Each one picks a source side and a random set of sinks per track. Directed cases cover the rest: both bits of a switch set, several sources competing for one side, track crossing, and drivers being cut off the moment a new shift starts.

// File: rtl/rbox_pkg.sv
package rbox_pkg;

  localparam int SIDES     = 4;
  localparam int PAIRS     = 6;
  localparam int SW_BITS   = 2;
  localparam int UNIT_BITS = PAIRS * SW_BITS;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  // lower-numbered side of switch p
  function automatic logic [1:0] pair_a(input int p);
    case (p)
      0, 1, 2: pair_a = SIDE_N;
      3, 4:    pair_a = SIDE_E;
      default: pair_a = SIDE_S;
    endcase
  endfunction

  // higher-numbered side of switch p
  function automatic logic [1:0] pair_b(input int p);
    case (p)
      0:       pair_b = SIDE_E;
      1, 3:    pair_b = SIDE_S;
      default: pair_b = SIDE_W;
    endcase
  endfunction

endpackage

// File: rtl/rbox_cfg_chain.sv
module rbox_cfg_chain #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[W-2:0], din};
    end
  end

  assign dout = q[W-1];

endmodule

// File: rtl/rbox_unit.sv
module rbox_unit
  import rbox_pkg::*;
(
  input  logic [UNIT_BITS-1:0]     cfg,
  input  logic                     quiet,
  output logic [SIDES-1:0]         drv_en,
  output logic [SIDES-1:0][1:0]    drv_sel
);

  always_comb begin
    drv_en  = '0;
    drv_sel = '0;
    // walk from the highest pair down so the lowest pair index wins
    for (int p = PAIRS - 1; p >= 0; p--) begin
      logic fwd;
      logic rev;
      logic [1:0] a;
      logic [1:0] b;
      a   = pair_a(p);
      b   = pair_b(p);
      fwd = cfg[SW_BITS*p]   & ~cfg[SW_BITS*p+1];
      rev = cfg[SW_BITS*p+1] & ~cfg[SW_BITS*p];
      if (fwd) begin
        drv_en[b]  = 1'b1;
        drv_sel[b] = a;
      end
      if (rev) begin
        drv_en[a]  = 1'b1;
        drv_sel[a] = b;
      end
    end
    if (quiet) begin
      drv_en = '0;
    end
  end

endmodule

// File: rtl/rbox_disjoint.sv
module rbox_disjoint
  import rbox_pkg::*;
#(
  parameter int TRACKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_shift,
  input  logic              cfg_din,
  output logic              cfg_dout,
  inout  wire [TRACKS-1:0]  io_n,
  inout  wire [TRACKS-1:0]  io_e,
  inout  wire [TRACKS-1:0]  io_s,
  inout  wire [TRACKS-1:0]  io_w
);

  localparam int CFG_W = TRACKS * UNIT_BITS;

  logic [CFG_W-1:0]                   cfg_q;
  logic [TRACKS-1:0][SIDES-1:0]       drv_en;
  logic [TRACKS-1:0][SIDES-1:0][1:0]  drv_sel;
  logic                               quiet;

  assign quiet = rst | cfg_shift;

  rbox_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_shift),
    .din      (cfg_din),
    .q        (cfg_q),
    .dout     (cfg_dout)
  );

  for (genvar t = 0; t < TRACKS; t++) begin : g_track
    logic [SIDES-1:0] cur;

    assign cur = {io_w[t], io_s[t], io_e[t], io_n[t]};

    rbox_unit u_unit (
      .cfg     (cfg_q[t*UNIT_BITS +: UNIT_BITS]),
      .quiet   (quiet),
      .drv_en  (drv_en[t]),
      .drv_sel (drv_sel[t])
    );

    assign io_n[t] = drv_en[t][SIDE_N] ? cur[drv_sel[t][SIDE_N]] : 1'bz;
    assign io_e[t] = drv_en[t][SIDE_E] ? cur[drv_sel[t][SIDE_E]] : 1'bz;
    assign io_s[t] = drv_en[t][SIDE_S] ? cur[drv_sel[t][SIDE_S]] : 1'bz;
    assign io_w[t] = drv_en[t][SIDE_W] ? cur[drv_sel[t][SIDE_W]] : 1'bz;
  end

endmodule

// File: rtl/rbox_disjoint_chk.sv
module rbox_disjoint_chk
  import rbox_pkg::*;
#(
  parameter int TRACKS = 3
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              cfg_shift,
  input logic                              cfg_din,
  input logic [TRACKS*UNIT_BITS-1:0]       cfg_q,
  input logic [TRACKS-1:0][SIDES-1:0]      drv_en,
  input logic [TRACKS-1:0][SIDES-1:0][1:0] drv_sel,
  input wire  [TRACKS-1:0]                 io_n,
  input wire  [TRACKS-1:0]                 io_e,
  input wire  [TRACKS-1:0]                 io_s,
  input wire  [TRACKS-1:0]                 io_w
);

  // R2: a shift pulls the serial input into the bottom of the chain
  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_shift |=> cfg_q[0] == $past(cfg_din));

  // R2: without a shift the stored bits stay put
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_shift |=> cfg_q == $past(cfg_q));

  // R3: no driver is on while the chain shifts
  p_quiet_load_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_shift |-> drv_en == '0);

  for (genvar t = 0; t < TRACKS; t++) begin : g_t
    logic [SIDES-1:0] cur;
    assign cur = {io_w[t], io_s[t], io_e[t], io_n[t]};
    for (genvar s = 0; s < SIDES; s++) begin : g_s
      // R10: a driven track settles to its source value, nothing fights it
      p_no_fight_r10: assert property (@(posedge clk) disable iff (rst)
        drv_en[t][s] |-> (cur[s] == cur[drv_sel[t][s]]
                          && drv_sel[t][s] != 2'(s)));
    end
  end

endmodule

bind rbox_disjoint rbox_disjoint_chk #(.TRACKS(TRACKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_shift (cfg_shift),
  .cfg_din   (cfg_din),
  .cfg_q     (cfg_q),
  .drv_en    (drv_en),
  .drv_sel   (drv_sel),
  .io_n      (io_n),
  .io_e      (io_e),
  .io_s      (io_s),
  .io_w      (io_w)
);

// File: tb/rbox_disjoint_test.sv
module rbox_disjoint_test;

  localparam int PERIOD = 10;
  localparam int TRK    = 3;
  localparam int CW     = TRK * 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_shift = 1'b0;
  logic cfg_din = 1'b0;
  logic cfg_dout;

  wire [TRK-1:0] w_n, w_e, w_s, w_w;
  logic [3:0][TRK-1:0] oe = '0;
  logic [3:0][TRK-1:0] dv = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < TRK; i++) begin : g_drv
    assign w_n[i] = oe[0][i] ? dv[0][i] : 1'bz;
    assign w_e[i] = oe[1][i] ? dv[1][i] : 1'bz;
    assign w_s[i] = oe[2][i] ? dv[2][i] : 1'bz;
    assign w_w[i] = oe[3][i] ? dv[3][i] : 1'bz;
    pulldown (w_n[i]);
    pulldown (w_e[i]);
    pulldown (w_s[i]);
    pulldown (w_w[i]);
  end

  rbox_disjoint #(.TRACKS(TRK)) uut (
    .clk       (clk),
    .rst       (rst),
    .cfg_shift (cfg_shift),
    .cfg_din   (cfg_din),
    .cfg_dout  (cfg_dout),
    .io_n      (w_n),
    .io_e      (w_e),
    .io_s      (w_s),
    .io_w      (w_w)
  );

  function automatic int side_a(int p);
    case (p)
      0, 1, 2: return 0;
      3, 4:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int side_b(int p);
    case (p)
      0:       return 1;
      1, 3:    return 2;
      default: return 3;
    endcase
  endfunction

  // bit index of switch p on track t; dir 0 = A drives B, 1 = B drives A
  function automatic int bit_of(int t, int p, int dir);
    return t * 12 + 2 * p + dir;
  endfunction

  function automatic logic rd(int s, int t);
    case (s)
      0:       return w_n[t];
      1:       return w_e[t];
      2:       return w_s[t];
      default: return w_w[t];
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [CW-1:0] word, output logic [CW-1:0] seen);
    @(negedge clk);
    cfg_shift = 1'b1;
    for (int k = 0; k < CW; k++) begin
      cfg_din = word[CW-1-k];
      #1;
      seen[CW-1-k] = cfg_dout;
      @(negedge clk);
    end
    cfg_shift = 1'b0;
    cfg_din   = 1'b0;
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [CW-1:0] word;
    logic [CW-1:0] seen;
    logic [CW-1:0] prev;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;

    // R1: nothing driven after reset, chain empty
    oe[0] = '1; dv[0] = '1;
    #1;
    for (int t = 0; t < TRK; t++)
      for (int s = 1; s < 4; s++)
        check(rd(s, t), 1'b0, "R1", $sformatf("side %0d track %0d after reset", s, t));
    check(cfg_dout, 1'b0, "R1", "cfg_dout after reset");
    oe = '0; dv = '0;

    // R2: serial chain returns the earlier word 36 shifts later
    prev = {$urandom, $urandom};
    load(prev, seen);
    word = '0;
    load(word, seen);
    for (int k = 0; k < CW; k++)
      check(seen[k], prev[k], "R2", $sformatf("dout bit %0d", k));

    // R3: track 0 N->E, then a new shift cuts it off at once
    word = '0;
    word[bit_of(0, 0, 0)] = 1'b1;
    load(word, seen);
    oe[0][0] = 1'b1; dv[0][0] = 1'b1;
    #1;
    check(rd(1, 0), 1'b1, "R4", "N->E before shift");
    // R5: other track indices stay untouched
    check(rd(1, 1), 1'b0, "R5", "E track 1 from N track 0");
    check(rd(1, 2), 1'b0, "R5", "E track 2 from N track 0");
    check(rd(2, 1), 1'b0, "R5", "S track 1 from N track 0");
    cfg_shift = 1'b1; cfg_din = 1'b0;
    #1;
    check(rd(1, 0), 1'b0, "R3", "E released during shift");
    @(negedge clk);
    cfg_shift = 1'b0;
    oe = '0; dv = '0;

    // R6: both bits of switch (N,E) set -> no drive either way
    word = '0;
    word[bit_of(1, 0, 0)] = 1'b1;
    word[bit_of(1, 0, 1)] = 1'b1;
    load(word, seen);
    oe[0][1] = 1'b1; dv[0][1] = 1'b1;
    #1;
    check(rd(1, 1), 1'b0, "R6", "E from N with both bits");
    oe = '0; dv = '0;
    oe[1][1] = 1'b1; dv[1][1] = 1'b1;
    #1;
    check(rd(0, 1), 1'b0, "R6", "N from E with both bits");
    oe = '0; dv = '0;

    // R9: E->N (pair 0), S->N (pair 1), W->N (pair 2) all target N track 2
    word = '0;
    word[bit_of(2, 0, 1)] = 1'b1;
    word[bit_of(2, 1, 1)] = 1'b1;
    word[bit_of(2, 2, 1)] = 1'b1;
    load(word, seen);
    oe[1][2] = 1'b1; oe[2][2] = 1'b1; oe[3][2] = 1'b1;
    dv[1][2] = 1'b1; dv[2][2] = 1'b0; dv[3][2] = 1'b0;
    #1;
    check(rd(0, 2), 1'b1, "R9", "N follows E (pair 0) high");
    dv[1][2] = 1'b0; dv[2][2] = 1'b1; dv[3][2] = 1'b1;
    #1;
    check(rd(0, 2), 1'b0, "R9", "N follows E (pair 0) low");
    oe = '0; dv = '0;

    // R7 R8 R10: random star settings, one source side per track
    for (int trial = 0; trial < 40; trial++) begin
      int src [TRK];
      logic [3:0] sink [TRK];
      word = '0;
      for (int t = 0; t < TRK; t++) begin
        src[t] = int'($urandom % 4);
        sink[t] = 4'($urandom) & ~(4'b1 << src[t]);
        if (trial < 4) sink[t] = 4'hF & ~(4'b1 << src[t]); // full fan-out
        for (int p = 0; p < 6; p++) begin
          if (side_a(p) == src[t] && sink[t][side_b(p)]) word[bit_of(t, p, 0)] = 1'b1;
          if (side_b(p) == src[t] && sink[t][side_a(p)]) word[bit_of(t, p, 1)] = 1'b1;
        end
      end
      load(word, seen);
      for (int pass = 0; pass < 2; pass++) begin
        for (int t = 0; t < TRK; t++) begin
          oe[src[t]][t] = 1'b1;
          dv[src[t]][t] = (pass == 0) ? 1'b1 : 1'b0;
        end
        #1;
        for (int t = 0; t < TRK; t++)
          for (int s = 0; s < 4; s++)
            if (s != src[t]) begin
              if (sink[t][s])
                check(rd(s, t), dv[src[t]][t], "R8 R10",
                      $sformatf("trial %0d track %0d %0d->%0d", trial, t, src[t], s));
              else
                check(rd(s, t), 1'b0, "R7",
                      $sformatf("trial %0d track %0d side %0d unrouted", trial, t, s));
            end
        oe = '0; dv = '0;
        #1;
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule